// File: doc/BRIEF.md
# UART Receive/Transmit Hardware Flow Controller

This block sits beside a UART and handles the two handshake lines of hardware flow control. On the receive side it watches the fill count of the receive FIFO. It drives the active-low request-to-send pin (`rts_n`) so that the far end is told to pause before the FIFO overflows. It does this with a hysteresis band: the pin turns off at an upper level and turns back on only below a lower level. It also raises a level-type receive-trigger interrupt while the fill count is at or above a programmable trigger level.

On the transmit side it synchronises the active-low clear-to-send input (`cts_n`) and presents a transmit-allow flag. The transmitter samples this flag before it starts each character. The flag only changes while the transmitter is between characters, so a character in flight is never cut short.

Each direction has its own enable bit, and both are expected off after reset. When automatic request-to-send is off, `rts_n` is just the inverse of a software bit, so the pin acts as a general-purpose output. When it is on, the automatic control only ever pulls the pin high on top of the software request. If software has not asserted the request, the pin stays high.

Top module: `uart_flow_ctrl`

## Requirements
- R1: While `rst` is high, and on the first clock edge after it, `rts_n` is 1, `rx_irq` is 0 and `tx_allow` is 1.
- R2: With `auto_rts_en` = 0, `rts_n` equals the inverse of `sw_rts` as sampled at the previous rising edge, whatever `rx_count` is.
- R3: `rx_irq` is 1 one cycle after a cycle in which `auto_rts_en` = 1 and `rx_count` >= `trig_lvl`, and it is 0 otherwise, including whenever `auto_rts_en` = 0.
- R4: With `auto_rts_en` = 1 and `sw_rts` = 1, `rts_n` is 1 one cycle after `rx_count` >= `hyst_hi`.
- R5: Once `rts_n` has been forced high by R4, it stays high while `hyst_lo` <= `rx_count` < `hyst_hi`. It returns to 0 one cycle after `rx_count` < `hyst_lo`, provided `sw_rts` = 1.
- R6: With `sw_rts` = 0, `rts_n` is 1 one cycle later in every mode.
- R7: With `hyst_hi` = `hyst_lo` = `trig_lvl`, `rts_n` acts as a single threshold: it is 1 for a count at or above the level and 0 for a count below it, one cycle after each count.
- R8: With `auto_cts_en` = 0 and `tx_busy` = 0, `tx_allow` is 1 regardless of `cts_n`.
- R9: With `auto_cts_en` = 1 and `tx_busy` = 0, `tx_allow` becomes the inverse of `cts_n` at the third rising edge after `cts_n` changes: two synchroniser stages, then one output register.
- R10: While `tx_busy` = 1, `tx_allow` holds its value. A pending change takes effect at the first rising edge at which `tx_busy` = 0.
- R11: Clearing `auto_rts_en` discards the hysteresis state. After it is set again with `rx_count` below `hyst_hi` and `sw_rts` = 1, `rts_n` is 0 one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_count | input | CW | Receive FIFO fill count, CW = clog2(FIFO_DEPTH+1) |
| trig_lvl | input | CW | Receive trigger level for the interrupt |
| hyst_hi | input | CW | Upper level; RTS is deasserted at or above it (must be >= trig_lvl) |
| hyst_lo | input | CW | Lower level; RTS is re-asserted below it (must be <= trig_lvl) |
| auto_rts_en | input | 1 | Enables automatic request-to-send control |
| auto_cts_en | input | 1 | Enables automatic clear-to-send gating |
| sw_rts | input | 1 | Software request-to-send, 1 = request active |
| cts_n | input | 1 | Clear-to-send from the far end, active low, asynchronous |
| tx_busy | input | 1 | Transmitter is in the middle of a character |
| rts_n | output | 1 | Request-to-send pin, active low, registered |
| rx_irq | output | 1 | Receive-trigger interrupt, level type, registered |
| tx_allow | output | 1 | Transmitter may start the next character |

## Verification
Every receive-side result (`rts_n` and `rx_irq`) is due exactly one rising edge after its inputs. So the bench applies each table vector at a falling edge and compares at the next falling edge. The transmit gate is due on the third rising edge after a change of `cts_n`. The bench samples it both after the second edge, where the old value must still hold, and after the third, where the new value must appear. For the busy case it holds `tx_busy` high well past that window, checks that the flag has not moved, and then expects the change one edge after `tx_busy` falls.

// File: rtl/uart_fc_pkg.sv
package uart_fc_pkg;

    localparam int DEFAULT_FIFO_DEPTH = 128;
    localparam int CTS_SYNC_STAGES    = 2;

    // Receive-side flow state held between the two hysteresis levels
    typedef enum logic {
        FLOW_ON  = 1'b0,
        FLOW_OFF = 1'b1
    } rx_flow_e;

    typedef struct packed {
        logic auto_rts;
        logic auto_cts;
        logic sw_rts;
    } fc_ctl_t;

    typedef struct packed {
        logic at_trig;
        logic at_hi;
        logic below_lo;
    } lvl_flags_t;

    function automatic rx_flow_e flow_next(rx_flow_e cur, logic en, lvl_flags_t f);
        rx_flow_e nxt;
        if (!en)
            nxt = FLOW_ON;
        else if (f.at_hi)
            nxt = FLOW_OFF;
        else if (f.below_lo)
            nxt = FLOW_ON;
        else
            nxt = cur;
        return nxt;
    endfunction

    // Active-low pin level: auto control can only pull the pin inactive
    function automatic logic rts_level(logic en, logic sw, rx_flow_e st);
        return (!sw) || (en && (st == FLOW_OFF));
    endfunction

endpackage

// File: rtl/fc_level_cmp.sv
module fc_level_cmp
    import uart_fc_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic [CW-1:0] count,
    input  logic [CW-1:0] trig,
    input  logic [CW-1:0] hi,
    input  logic [CW-1:0] lo,
    output lvl_flags_t    flags
);
    always_comb begin
        flags.at_trig  = (count >= trig);
        flags.at_hi    = (count >= hi);
        flags.below_lo = (count < lo);
    end
endmodule

// File: rtl/fc_rts_ctrl.sv
module fc_rts_ctrl
    import uart_fc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  fc_ctl_t    ctl,
    input  lvl_flags_t flags,
    output logic       rts_n,
    output logic       irq
);
    rx_flow_e state_q;
    rx_flow_e state_d;

    always_comb begin
        state_d = flow_next(state_q, ctl.auto_rts, flags);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FLOW_ON;
            rts_n   <= 1'b1;
            irq     <= 1'b0;
        end else begin
            state_q <= state_d;
            rts_n   <= rts_level(ctl.auto_rts, ctl.sw_rts, state_d);
            irq     <= ctl.auto_rts && flags.at_trig;
        end
    end
endmodule

// File: rtl/fc_cts_gate.sv
module fc_cts_gate #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic cts_n,
    input  logic busy,
    output logic allow
);
    logic [STAGES-1:0] sync_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_sync
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) sync_q[i] <= 1'b1;
                    else     sync_q[i] <= cts_n;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) sync_q[i] <= 1'b1;
                    else     sync_q[i] <= sync_q[i-1];
                end
            end
        end
    endgenerate

    // Decision only moves between characters
    always_ff @(posedge clk) begin
        if (rst)
            allow <= 1'b1;
        else if (!busy)
            allow <= (!en) || (!sync_q[STAGES-1]);
    end
endmodule

// File: rtl/uart_flow_ctrl.sv
module uart_flow_ctrl
    import uart_fc_pkg::*;
#(
    parameter int FIFO_DEPTH = DEFAULT_FIFO_DEPTH,
    localparam int CW        = $clog2(FIFO_DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] rx_count,
    input  logic [CW-1:0] trig_lvl,
    input  logic [CW-1:0] hyst_hi,
    input  logic [CW-1:0] hyst_lo,
    input  logic          auto_rts_en,
    input  logic          auto_cts_en,
    input  logic          sw_rts,
    input  logic          cts_n,
    input  logic          tx_busy,
    output logic          rts_n,
    output logic          rx_irq,
    output logic          tx_allow
);
    fc_ctl_t    ctl;
    lvl_flags_t flags;

    always_comb begin
        ctl.auto_rts = auto_rts_en;
        ctl.auto_cts = auto_cts_en;
        ctl.sw_rts   = sw_rts;
    end

    fc_level_cmp #(.CW(CW)) u_cmp (
        .count (rx_count),
        .trig  (trig_lvl),
        .hi    (hyst_hi),
        .lo    (hyst_lo),
        .flags (flags)
    );

    fc_rts_ctrl u_rts (
        .clk   (clk),
        .rst   (rst),
        .ctl   (ctl),
        .flags (flags),
        .rts_n (rts_n),
        .irq   (rx_irq)
    );

    fc_cts_gate #(.STAGES(CTS_SYNC_STAGES)) u_cts (
        .clk   (clk),
        .rst   (rst),
        .en    (ctl.auto_cts),
        .cts_n (cts_n),
        .busy  (tx_busy),
        .allow (tx_allow)
    );
endmodule

// File: rtl/uart_flow_ctrl_chk.sv
module uart_flow_ctrl_chk #(
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic [CW-1:0] rx_count,
    input logic [CW-1:0] trig_lvl,
    input logic [CW-1:0] hyst_hi,
    input logic [CW-1:0] hyst_lo,
    input logic          auto_rts_en,
    input logic          auto_cts_en,
    input logic          sw_rts,
    input logic          tx_busy,
    input logic          rts_n,
    input logic          rx_irq,
    input logic          tx_allow
);
    // High once a full cycle out of reset has passed, so $past is meaningful
    logic live;
    always_ff @(posedge clk) begin
        if (rst) live <= 1'b0;
        else     live <= 1'b1;
    end

    p_reset_out_r1: assert property (@(posedge clk)
        (!live && !rst) |-> (rts_n && !rx_irq && tx_allow));

    p_gpo_follow_r2: assert property (@(posedge clk) disable iff (rst)
        (live && !$past(auto_rts_en)) |-> (rts_n == !$past(sw_rts)));

    p_irq_level_r3: assert property (@(posedge clk) disable iff (rst)
        live |-> (rx_irq == ($past(auto_rts_en) && ($past(rx_count) >= $past(trig_lvl)))));

    p_upper_off_r4: assert property (@(posedge clk) disable iff (rst)
        (live && $past(auto_rts_en) && $past(rx_count) >= $past(hyst_hi)) |-> rts_n);

    p_lower_on_r5: assert property (@(posedge clk) disable iff (rst)
        (live && $past(auto_rts_en) && $past(sw_rts)
         && $past(rx_count) < $past(hyst_lo) && $past(rx_count) < $past(hyst_hi)) |-> !rts_n);

    p_sw_inactive_r6: assert property (@(posedge clk) disable iff (rst)
        (live && !$past(sw_rts)) |-> rts_n);

    p_cts_off_r8: assert property (@(posedge clk) disable iff (rst)
        (live && !$past(auto_cts_en) && !$past(tx_busy)) |-> tx_allow);

    p_busy_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (live && $past(tx_busy)) |-> $stable(tx_allow));
endmodule

bind uart_flow_ctrl uart_flow_ctrl_chk #(.CW(CW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .rx_count    (rx_count),
    .trig_lvl    (trig_lvl),
    .hyst_hi     (hyst_hi),
    .hyst_lo     (hyst_lo),
    .auto_rts_en (auto_rts_en),
    .auto_cts_en (auto_cts_en),
    .sw_rts      (sw_rts),
    .tx_busy     (tx_busy),
    .rts_n       (rts_n),
    .rx_irq      (rx_irq),
    .tx_allow    (tx_allow)
);

// File: tb/uart_flow_ctrl_tb.sv
module uart_flow_ctrl_tb;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [CW-1:0] rx_count = '0;
    logic [CW-1:0] trig_lvl = 8'd8;
    logic [CW-1:0] hyst_hi  = 8'd12;
    logic [CW-1:0] hyst_lo  = 8'd4;
    logic          auto_rts_en = 1'b0;
    logic          auto_cts_en = 1'b0;
    logic          sw_rts  = 1'b0;
    logic          cts_n   = 1'b0;
    logic          tx_busy = 1'b0;
    logic          rts_n;
    logic          rx_irq;
    logic          tx_allow;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    uart_flow_ctrl #(.FIFO_DEPTH(128)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .rx_count    (rx_count),
        .trig_lvl    (trig_lvl),
        .hyst_hi     (hyst_hi),
        .hyst_lo     (hyst_lo),
        .auto_rts_en (auto_rts_en),
        .auto_cts_en (auto_cts_en),
        .sw_rts      (sw_rts),
        .cts_n       (cts_n),
        .tx_busy     (tx_busy),
        .rts_n       (rts_n),
        .rx_irq      (rx_irq),
        .tx_allow    (tx_allow)
    );

    // {auto_rts, sw_rts, count[7:0], exp_rts_n, exp_irq}; levels trig=8 hi=12 lo=4
    localparam logic [11:0] VEC [12] = '{
        {1'b1, 1'b1, 8'd0,  1'b0, 1'b0},  // R3 below trigger
        {1'b1, 1'b1, 8'd8,  1'b0, 1'b1},  // R3 at trigger, R5 still on
        {1'b1, 1'b1, 8'd12, 1'b1, 1'b1},  // R4 upper level
        {1'b1, 1'b1, 8'd6,  1'b1, 1'b0},  // R5 band hold, R3 irq clears
        {1'b1, 1'b1, 8'd4,  1'b1, 1'b0},  // R5 at lower level still off
        {1'b1, 1'b1, 8'd3,  1'b0, 1'b0},  // R5 below lower level
        {1'b1, 1'b1, 8'd11, 1'b0, 1'b1},  // R5 rising inside band
        {1'b1, 1'b0, 8'd11, 1'b1, 1'b1},  // R6 software inactive
        {1'b1, 1'b1, 8'd13, 1'b1, 1'b1},  // R4 above upper
        {1'b0, 1'b1, 8'd13, 1'b0, 1'b0},  // R2 plain output, R3 no irq
        {1'b0, 1'b0, 8'd2,  1'b1, 1'b0},  // R2 plain output high
        {1'b1, 1'b1, 8'd10, 1'b0, 1'b1}   // R11 state discarded
    };

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        int wd = 0;
        while (!done && wd < 20000) begin
            @(posedge clk);
            wd++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        cycles(3);
        check("R1", "rts_n in reset", rts_n, 1'b1);
        check("R1", "rx_irq in reset", rx_irq, 1'b0);
        check("R1", "tx_allow in reset", tx_allow, 1'b1);
        rst = 1'b0;
        cycles(1);
        check("R1", "rts_n after reset", rts_n, 1'b1);

        foreach (VEC[k]) begin
            auto_rts_en = VEC[k][11];
            sw_rts      = VEC[k][10];
            rx_count    = VEC[k][9:2];
            cycles(1);
            check("R2-6,R11", $sformatf("vec %0d rts_n", k), rts_n, VEC[k][1]);
            check("R3", $sformatf("vec %0d rx_irq", k), rx_irq, VEC[k][0]);
        end

        // R7: all three levels equal
        hyst_hi = 8'd8; hyst_lo = 8'd8; trig_lvl = 8'd8;
        auto_rts_en = 1'b1; sw_rts = 1'b1;
        rx_count = 8'd8; cycles(1); check("R7", "at level", rts_n, 1'b1);
        rx_count = 8'd7; cycles(1); check("R7", "below level", rts_n, 1'b0);
        rx_count = 8'd8; cycles(1); check("R7", "back at level", rts_n, 1'b1);

        // R8: gating off, CTS inactive
        cts_n = 1'b1; cycles(4);
        check("R8", "cts ignored", tx_allow, 1'b1);

        // R9: gating on
        cts_n = 1'b0; cycles(4);
        auto_cts_en = 1'b1; cycles(4);
        check("R9", "cts active", tx_allow, 1'b1);
        cts_n = 1'b1; cycles(2);
        check("R9", "after two edges", tx_allow, 1'b1);
        cycles(1);
        check("R9", "after three edges", tx_allow, 1'b0);
        cts_n = 1'b0; cycles(2);
        check("R9", "resume two edges", tx_allow, 1'b1 ^ 1'b1);
        cycles(1);
        check("R9", "resume three edges", tx_allow, 1'b1);

        // R10: busy holds the decision
        tx_busy = 1'b1; cts_n = 1'b1; cycles(6);
        check("R10", "held while busy", tx_allow, 1'b1);
        tx_busy = 1'b0; cycles(1);
        check("R10", "applied at boundary", tx_allow, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule